// File: doc/BRIEF.md
# Data Memory Address Generator

This block turns the operand fields of a decoded instruction into the 12-bit address used by the data RAM of an 8-bit microcontroller datapath. It also tells the write-back stage whether the result goes to the working register or back to the file register. The block supports three ways of forming the address: an 8-bit operand placed in a bank chosen by a 4-bit bank register, the same operand forced into a fixed access bank, and a complete 12-bit address supplied by file-to-file moves.

The block holds three 12-bit pointer registers for indirect access. An indirect access can use a pointer as it is, or step the pointer up or down by one after the access, or add the working register to it as a signed offset. When a pointer is stepped, the block raises a one-cycle strobe. The pointers and the bank register sit in the special function register area. Ordinary register-file writes load them, and ordinary reads return their values. The ALU, the decoder and the RAM array are outside this block.

Top module: `dmag_top`

## Requirements
- R1: After reset the bank register and every byte of all three pointers read back as zero.
- R2: When the bank flag `op_bank_en` is 1 (with neither full nor indirect access), `eff_addr` is `{bank, op_addr}`.
- R3: When `op_bank_en` is 0, operands 0x00..0x5F map to 0x000..0x05F and operands 0x60..0xFF map to 0xF60..0xFFF, whatever the bank register holds.
- R4: Address source priority is: full address (`full_en`) first, then indirect (`ind_en`), then direct. A full address ignores the bank register.
- R5: `dest_file` is 1 when `op_dest` is 1 (result to file) and 0 when `op_dest` is 0 (result to working register).
- R6: Register-port map: pointer n has its low byte at 0xFE0+2n and its upper 4 bits at 0xFE1+2n, read back with the top 4 bits zero. The bank register is the low nibble at 0xFE6. Any other address reads 0x00, and writes to it change nothing.
- R7: Indirect mode codes are 0 = plain, 1 = post-increment, 2 = post-decrement and 3 = offset. `eff_addr` is the pointer value before any update. Increment and decrement take effect at the clock edge and wrap modulo 4096. `ptr_inc[n]`/`ptr_dec[n]` pulse for that access.
- R8: In offset mode, `eff_addr` = pointer + sign-extended `wreg` (modulo 4096), and the pointer is left unchanged.
- R9: If a register-port write hits a byte of the pointer that is being stepped in the same cycle, the step is dropped. The written byte takes the new value and the other byte keeps its old value.
- R10: An indirect select of 3 or more gives `eff_addr` 0x000, raises no strobe and changes no pointer.
- R11: A pointer loaded with 0x100 and stepped by post-increment covers 0x100..0x1FF in 256 accesses. It then reads 0x200, with bit 1 of its high byte set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_addr | input | 8 | Operand register address |
| op_bank_en | input | 1 | 1 = banked, 0 = access bank |
| op_dest | input | 1 | Destination flag |
| full_en | input | 1 | Use full 12-bit address |
| full_addr | input | 12 | Full operand address |
| ind_en | input | 1 | Indirect access request |
| ind_sel | input | 2 | Pointer select |
| ind_mode | input | 2 | Indirect mode code |
| wreg | input | 8 | Working register value (offset) |
| rf_we | input | 1 | Register-port write enable |
| rf_waddr | input | 12 | Register-port write address |
| rf_wdata | input | 8 | Register-port write data |
| rf_raddr | input | 12 | Register-port read address |
| rf_rdata | output | 8 | Register-port read data |
| eff_addr | output | 12 | Effective data address |
| dest_file | output | 1 | 1 = file, 0 = working register |
| ptr_inc | output | 3 | Post-increment strobes |
| ptr_dec | output | 3 | Post-decrement strobes |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 8-bit operands, three pointers, the register window at 0xFE0 and the access-bank split at 0x60. With these values both pointer wrap points (0xFFF to 0x000 and back) can be reached in a single step. The access-bank boundary sits at operands 0x5F/0x60. A full 256-step sweep of bank 1 fits in a short run, so the loop-termination test on the high byte is checked end to end.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    typedef enum logic [1:0] {
        IND_PLAIN   = 2'd0,
        IND_POSTINC = 2'd1,
        IND_POSTDEC = 2'd2,
        IND_OFFSET  = 2'd3
    } ind_mode_e;
endpackage

// File: rtl/dmag_direct_map.sv
module dmag_direct_map #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int ACC_SPLIT = 'h60
) (
    input  logic [DATA_W-1:0]        op_addr,
    input  logic                     op_bank_en,
    input  logic [ADDR_W-DATA_W-1:0] bank,
    output logic [ADDR_W-1:0]        dir_addr
);
    localparam int BANK_W = ADDR_W - DATA_W;

    always_comb begin
        if (op_bank_en) begin
            dir_addr = {bank, op_addr};
        end else if (op_addr < DATA_W'(ACC_SPLIT)) begin
            dir_addr = {{BANK_W{1'b0}}, op_addr};
        end else begin
            dir_addr = {{BANK_W{1'b1}}, op_addr};
        end
    end
endmodule

// File: rtl/dmag_ind_path.sv
module dmag_ind_path
    import dmag_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int NUM_PTR = 3,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_PTR*ADDR_W-1:0] ptr_flat,
    input  logic                      ind_en,
    input  logic [SEL_W-1:0]          ind_sel,
    input  logic [1:0]                ind_mode,
    input  logic [DATA_W-1:0]         wreg,
    output logic [ADDR_W-1:0]         ind_addr,
    output logic [NUM_PTR-1:0]        inc_stb,
    output logic [NUM_PTR-1:0]        dec_stb
);
    localparam int EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] sel_ptr;
    logic              sel_ok;
    logic [ADDR_W-1:0] wreg_sx;

    always_comb begin
        sel_ptr = '0;
        sel_ok  = 1'b0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (ind_sel == SEL_W'(i)) begin
                sel_ptr = ptr_flat[i*ADDR_W +: ADDR_W];
                sel_ok  = 1'b1;
            end
        end
        wreg_sx = {{EXT_W{wreg[DATA_W-1]}}, wreg};
        if (!sel_ok) begin
            ind_addr = '0;
        end else if (ind_mode == IND_OFFSET) begin
            ind_addr = sel_ptr + wreg_sx;
        end else begin
            ind_addr = sel_ptr;
        end
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_stb
        assign inc_stb[g] = ind_en && (ind_sel == SEL_W'(g)) && (ind_mode == IND_POSTINC);
        assign dec_stb[g] = ind_en && (ind_sel == SEL_W'(g)) && (ind_mode == IND_POSTDEC);
    end
endmodule

// File: rtl/dmag_ptr_file.sv
module dmag_ptr_file #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int NUM_PTR  = 3,
    parameter int SFR_BASE = 'hFE0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rf_we,
    input  logic [ADDR_W-1:0]           rf_waddr,
    input  logic [DATA_W-1:0]           rf_wdata,
    input  logic [ADDR_W-1:0]           rf_raddr,
    output logic [DATA_W-1:0]           rf_rdata,
    input  logic [NUM_PTR-1:0]          inc_stb,
    input  logic [NUM_PTR-1:0]          dec_stb,
    output logic [NUM_PTR*ADDR_W-1:0]   ptr_flat,
    output logic [ADDR_W-DATA_W-1:0]    bank
);
    localparam int BANK_W    = ADDR_W - DATA_W;
    localparam int BANK_ADDR = SFR_BASE + 2 * NUM_PTR;

    typedef struct packed {
        logic [NUM_PTR-1:0][ADDR_W-1:0] ptr;
        logic [BANK_W-1:0]              bank;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_PTR-1:0] lo_hit, hi_hit;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_hit
        assign lo_hit[g] = rf_we && (rf_waddr == ADDR_W'(SFR_BASE + 2 * g));
        assign hi_hit[g] = rf_we && (rf_waddr == ADDR_W'(SFR_BASE + 2 * g + 1));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (lo_hit[i] || hi_hit[i]) begin
                if (lo_hit[i]) st_d.ptr[i][DATA_W-1:0] = rf_wdata;
                if (hi_hit[i]) st_d.ptr[i][ADDR_W-1:DATA_W] = rf_wdata[BANK_W-1:0];
            end else if (inc_stb[i]) begin
                st_d.ptr[i] = st_q.ptr[i] + 1'b1;
            end else if (dec_stb[i]) begin
                st_d.ptr[i] = st_q.ptr[i] - 1'b1;
            end
        end
        if (rf_we && (rf_waddr == ADDR_W'(BANK_ADDR))) begin
            st_d.bank = rf_wdata[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rf_rdata = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (rf_raddr == ADDR_W'(SFR_BASE + 2 * i))
                rf_rdata = st_q.ptr[i][DATA_W-1:0];
            if (rf_raddr == ADDR_W'(SFR_BASE + 2 * i + 1))
                rf_rdata = DATA_W'(st_q.ptr[i][ADDR_W-1:DATA_W]);
        end
        if (rf_raddr == ADDR_W'(BANK_ADDR)) rf_rdata = DATA_W'(st_q.bank);
    end

    assign ptr_flat = st_q.ptr;
    assign bank     = st_q.bank;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_chk
        // R7: an unobstructed increment advances by one, wrapping
        p_postinc_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_stb[g] && !lo_hit[g] && !hi_hit[g])
            |=> st_q.ptr[g] == ADDR_W'($past(st_q.ptr[g]) + 1'b1));
        // R7: an unobstructed decrement steps back by one
        p_postdec_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_stb[g] && !lo_hit[g] && !hi_hit[g])
            |=> st_q.ptr[g] == ADDR_W'($past(st_q.ptr[g]) - 1'b1));
        // R9: a low-byte write beats a same-cycle step
        p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            lo_hit[g] |=> st_q.ptr[g][DATA_W-1:0] == $past(rf_wdata));
        // R8/R10: without a step or a write the pointer holds
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!inc_stb[g] && !dec_stb[g] && !lo_hit[g] && !hi_hit[g])
            |=> $stable(st_q.ptr[g]));
    end
endmodule

// File: rtl/dmag_top.sv
module dmag_top #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int NUM_PTR   = 3,
    parameter int SFR_BASE  = 'hFE0,
    parameter int ACC_SPLIT = 'h60,
    parameter int SEL_W     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    op_addr,
    input  logic                 op_bank_en,
    input  logic                 op_dest,
    input  logic                 full_en,
    input  logic [ADDR_W-1:0]    full_addr,
    input  logic                 ind_en,
    input  logic [SEL_W-1:0]     ind_sel,
    input  logic [1:0]           ind_mode,
    input  logic [DATA_W-1:0]    wreg,
    input  logic                 rf_we,
    input  logic [ADDR_W-1:0]    rf_waddr,
    input  logic [DATA_W-1:0]    rf_wdata,
    input  logic [ADDR_W-1:0]    rf_raddr,
    output logic [DATA_W-1:0]    rf_rdata,
    output logic [ADDR_W-1:0]    eff_addr,
    output logic                 dest_file,
    output logic [NUM_PTR-1:0]   ptr_inc,
    output logic [NUM_PTR-1:0]   ptr_dec
);
    localparam int BANK_W = ADDR_W - DATA_W;

    logic [NUM_PTR*ADDR_W-1:0] ptr_flat;
    logic [BANK_W-1:0]         bank;
    logic [ADDR_W-1:0]         dir_addr, ind_addr;
    logic [NUM_PTR-1:0]        inc_stb, dec_stb;

    dmag_direct_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_SPLIT(ACC_SPLIT)) u_dir (
        .op_addr(op_addr), .op_bank_en(op_bank_en), .bank(bank), .dir_addr(dir_addr));

    dmag_ind_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_ind (
        .ptr_flat(ptr_flat), .ind_en(ind_en), .ind_sel(ind_sel), .ind_mode(ind_mode),
        .wreg(wreg), .ind_addr(ind_addr), .inc_stb(inc_stb), .dec_stb(dec_stb));

    dmag_ptr_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .SFR_BASE(SFR_BASE)) u_ptr (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .inc_stb(inc_stb), .dec_stb(dec_stb),
        .ptr_flat(ptr_flat), .bank(bank));

    always_comb begin
        if (full_en)     eff_addr = full_addr;
        else if (ind_en) eff_addr = ind_addr;
        else             eff_addr = dir_addr;
    end

    assign dest_file = op_dest;
    assign ptr_inc   = inc_stb;
    assign ptr_dec   = dec_stb;

    // R4: full address overrides every other source
    p_full_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full_en |-> eff_addr == full_addr);
    // R7: at most one pointer strobe per access
    p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ptr_inc, ptr_dec}));
    // R2: banked direct address uses the bank register
    p_bank_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en && !ind_en && op_bank_en) |-> eff_addr[ADDR_W-1:DATA_W] == bank);
    // R10: an out-of-range select raises no strobe
    p_bad_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_sel >= SEL_W'(NUM_PTR)) |-> (ptr_inc == '0 && ptr_dec == '0));
endmodule

// File: tb/tb_dmag_top.sv
module tb_dmag_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  op_addr = '0;
    logic        op_bank_en = 1'b0, op_dest = 1'b0, full_en = 1'b0, ind_en = 1'b0, rf_we = 1'b0;
    logic [11:0] full_addr = '0, rf_waddr = '0, rf_raddr = '0;
    logic [1:0]  ind_sel = '0, ind_mode = '0;
    logic [7:0]  wreg = '0, rf_wdata = '0;
    logic [7:0]  rf_rdata;
    logic [11:0] eff_addr;
    logic        dest_file;
    logic [2:0]  ptr_inc, ptr_dec;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dmag_top dut (
        .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .op_bank_en(op_bank_en), .op_dest(op_dest),
        .full_en(full_en), .full_addr(full_addr), .ind_en(ind_en), .ind_sel(ind_sel),
        .ind_mode(ind_mode), .wreg(wreg), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .eff_addr(eff_addr),
        .dest_file(dest_file), .ptr_inc(ptr_inc), .ptr_dec(ptr_dec));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_bank_en = 0; full_en = 0; ind_en = 0; rf_we = 0; ind_mode = 0; ind_sel = 0;
    endtask

    task automatic rf_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        rf_we = 1; rf_waddr = a; rf_wdata = d;
        @(posedge clk); #1;
        rf_we = 0;
    endtask

    task automatic rf_read(input logic [11:0] a, output logic [7:0] d);
        rf_raddr = a; #1; d = rf_rdata;
    endtask

    task automatic set_ptr(input int n, input logic [11:0] v);
        rf_write(12'(12'hFE0 + 2 * n), v[7:0]);
        rf_write(12'(12'hFE1 + 2 * n), {4'h0, v[11:8]});
    endtask

    task automatic get_ptr(input int n, output logic [11:0] v);
        logic [7:0] lo, hi;
        rf_read(12'(12'hFE0 + 2 * n), lo);
        rf_read(12'(12'hFE1 + 2 * n), hi);
        v = {hi[3:0], lo};
    endtask

    // one indirect access over one clock edge; returns the address seen before the edge
    task automatic ind_access(input int n, input logic [1:0] m, output logic [11:0] a,
                              output logic [2:0] inc, output logic [2:0] dec);
        @(negedge clk);
        ind_en = 1; ind_sel = 2'(n); ind_mode = m; #1;
        a = eff_addr; inc = ptr_inc; dec = ptr_dec;
        @(posedge clk); #1;
        ind_en = 0; ind_mode = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 12'hFE0; a <= 12'hFE6; a++) begin
            rf_read(12'(a), d);
            chk("R1 reset byte", {8'h0, d}, 16'h0);
        end
        @(negedge clk); op_bank_en = 1; op_addr = 8'h34; #1;
        chk("R1 reset bank in address", {4'h0, eff_addr}, 16'h034);
        idle();
    endtask

    task automatic t_direct();
        rf_write(12'hFE6, 8'h05);
        @(negedge clk); op_bank_en = 1; op_addr = 8'hA7; #1;
        chk("R2 banked", {4'h0, eff_addr}, 16'h5A7);
        rf_write(12'hFE6, 8'h0F);
        @(negedge clk); op_addr = 8'h00; #1;
        chk("R2 banked top", {4'h0, eff_addr}, 16'hF00);
        rf_write(12'hFE6, 8'h05);
        @(negedge clk); op_bank_en = 0;
        op_addr = 8'h00; #1; chk("R3 access low", {4'h0, eff_addr}, 16'h000);
        op_addr = 8'h5F; #1; chk("R3 access 0x5F", {4'h0, eff_addr}, 16'h05F);
        op_addr = 8'h60; #1; chk("R3 access 0x60", {4'h0, eff_addr}, 16'hF60);
        op_addr = 8'hFF; #1; chk("R3 access 0xFF", {4'h0, eff_addr}, 16'hFFF);
        idle();
    endtask

    task automatic t_priority();
        set_ptr(0, 12'h345);
        @(negedge clk);
        op_bank_en = 1; op_addr = 8'h11; ind_en = 1; ind_sel = 0; ind_mode = 0;
        full_en = 1; full_addr = 12'h123; #1;
        chk("R4 full wins", {4'h0, eff_addr}, 16'h123);
        full_en = 0; #1;
        chk("R4 indirect over direct", {4'h0, eff_addr}, 16'h345);
        idle();
    endtask

    task automatic t_dest();
        @(negedge clk); op_dest = 1; #1; chk("R5 dest file", {15'h0, dest_file}, 16'h1);
        op_dest = 0; #1; chk("R5 dest W", {15'h0, dest_file}, 16'h0);
    endtask

    task automatic t_map();
        logic [7:0] d;
        rf_write(12'hFE7, 8'hAA);
        rf_read(12'hFE7, d); chk("R6 unmapped read", {8'h0, d}, 16'h0);
        rf_write(12'hFE3, 8'hFF);
        rf_read(12'hFE3, d); chk("R6 high nibble only", {8'h0, d}, 16'h0F);
        rf_write(12'hFE2, 8'h3C);
        rf_read(12'hFE2, d); chk("R6 low byte", {8'h0, d}, 16'h3C);
    endtask

    task automatic t_step();
        logic [11:0] a, v; logic [2:0] i, dd;
        set_ptr(1, 12'h0FF);
        ind_access(1, 2'd1, a, i, dd);
        chk("R7 postinc address", {4'h0, a}, 16'h0FF);
        chk("R7 inc strobe", {13'h0, i}, 16'h2);
        get_ptr(1, v); chk("R7 postinc value", {4'h0, v}, 16'h100);
        set_ptr(2, 12'h000);
        ind_access(2, 2'd2, a, i, dd);
        chk("R7 postdec address", {4'h0, a}, 16'h000);
        chk("R7 dec strobe", {13'h0, dd}, 16'h4);
        get_ptr(2, v); chk("R7 postdec wrap", {4'h0, v}, 16'hFFF);
        ind_access(2, 2'd1, a, i, dd);
        get_ptr(2, v); chk("R7 postinc wrap", {4'h0, v}, 16'h000);
    endtask

    task automatic t_offset();
        logic [11:0] a, v; logic [2:0] i, dd;
        set_ptr(0, 12'h010);
        wreg = 8'hF0;
        ind_access(0, 2'd3, a, i, dd);
        chk("R8 negative offset", {4'h0, a}, 16'h000);
        chk("R8 no strobe", {10'h0, i, dd}, 16'h0);
        get_ptr(0, v); chk("R8 pointer kept", {4'h0, v}, 16'h010);
        wreg = 8'h7F;
        ind_access(0, 2'd3, a, i, dd);
        chk("R8 positive offset", {4'h0, a}, 16'h08F);
        set_ptr(0, 12'hFF8); wreg = 8'h10;
        ind_access(0, 2'd3, a, i, dd);
        chk("R8 offset wrap", {4'h0, a}, 16'h008);
    endtask

    task automatic t_collide();
        logic [11:0] v;
        set_ptr(1, 12'h200);
        @(negedge clk);
        ind_en = 1; ind_sel = 1; ind_mode = 2'd1;
        rf_we = 1; rf_waddr = 12'hFE2; rf_wdata = 8'h55;
        @(posedge clk); #1;
        idle();
        get_ptr(1, v); chk("R9 write wins", {4'h0, v}, 16'h255);
    endtask

    task automatic t_bad_sel();
        logic [11:0] a, v0, v1, v2, w0, w1, w2; logic [2:0] i, dd;
        get_ptr(0, v0); get_ptr(1, v1); get_ptr(2, v2);
        ind_access(3, 2'd1, a, i, dd);
        chk("R10 address zero", {4'h0, a}, 16'h000);
        chk("R10 no strobe", {10'h0, i, dd}, 16'h0);
        get_ptr(0, w0); get_ptr(1, w1); get_ptr(2, w2);
        chk("R10 pointers unchanged", {4'h0, w0 ^ v0 | w1 ^ v1 | w2 ^ v2}, 16'h0);
    endtask

    task automatic t_sweep();
        logic [7:0] hi; logic [11:0] v;
        int steps = 0, bad = 0;
        set_ptr(0, 12'h100);
        rf_raddr = 12'hFE1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            ind_en = 1; ind_sel = 0; ind_mode = 2'd1; #1;
            if (eff_addr !== 12'(12'h100 + k)) bad++;
            @(posedge clk); #1;
            ind_en = 0;
            steps++;
            if (rf_rdata[1]) break;
        end
        chk("R11 sweep steps", 16'(steps), 16'd256);
        chk("R11 sweep addresses", 16'(bad), 16'd0);
        get_ptr(0, v); chk("R11 end pointer", {4'h0, v}, 16'h200);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_direct();
        t_priority();
        t_dest();
        t_map();
        t_step();
        t_offset();
        t_collide();
        t_bad_sel();
        t_sweep();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule